// File: doc/BRIEF.md
# Normal-Scan Launch/Capture Sequencer

This block sequences a two-vector delay test applied through an ordinary scan chain that has no hold latches. It loads the first vector into the chain with slow shift strobes. It then launches the second vector in one of two ways, chosen per pattern. The first way is one more scan shift, so V2 is V1 moved by one bit. The second way is one normal-mode clock, in which the logic's response to V1 becomes V2. Exactly one rated-period interval later it issues the capture strobe. The captured response is then shifted out with slow strobes.

The block drives an external clocking stage with one-cycle enables. A slow enable requests a test-clock edge that follows a long gap. A rated enable requests the capture edge, which comes a rated period after the launch edge. The block also drives the scan/normal test-control level, a select that switches the primary inputs from V1 to V2, and flags that tell the tester whether a given shift carries load data, unload data or both. When another pattern is requested while a capture completes, the unload shifts also load the next V1, and the next launch follows straight after them.

Top module: `scan_launch_seq`

## Requirements
- R1: In reset and immediately after it, scan_en, slow_en, rated_en, pi_v2, shift_in_valid, shift_out_valid and busy are all 0.
- R2: A pattern started from idle (pattern_req high at a clock edge while busy is 0) begins with CHAIN_LEN slow_en strobes spaced SLOW_GAP cycles apart, each with scan_en=1, shift_in_valid=1, shift_out_valid=0 and pi_v2=0.
- R3: With launch_sel=0 (shift launch), a slow_en launch strobe follows the last load strobe by SLOW_GAP cycles with scan_en=1. scan_en is 0 in the cycle after the launch strobe and at the capture strobe.
- R4: With launch_sel=1 (functional launch), scan_en is 0 in every cycle from the one after the last load strobe through the launch strobe. That launch strobe is a slow_en strobe SLOW_GAP cycles after the last load strobe.
- R5: Each pattern gets exactly one rated_en strobe, exactly RATED_GAP cycles after its launch strobe, with scan_en=0 and pi_v2=1.
- R6: pi_v2 is 0 at every load, launch and unload strobe and 1 at the capture strobe.
- R7: After the capture strobe, CHAIN_LEN slow_en unload strobes follow, spaced SLOW_GAP cycles apart (the first SLOW_GAP after capture), with scan_en=1 and shift_out_valid=1. Without a pending request, busy then returns to 0.
- R8: If pattern_req is high at the edge that ends the capture-strobe cycle, the unload strobes also carry shift_in_valid=1. The next pattern's launch strobe follows the last of them by SLOW_GAP cycles, with no separate load phase.
- R9: rated_en never occurs together with slow_en, and never outside the launch-to-capture interval, so there is one rated_en per pattern in total.
- R10: launch_sel is sampled only when a load begins, either from idle or at an overlapping capture. Changes to it during a load have no effect on that pattern's launch waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pattern_req | input | 1 | A pattern is pending (level) |
| launch_sel | input | 1 | 0 = launch by one extra shift, 1 = launch by a functional clock |
| scan_en | output | 1 | Test control: 1 = scan mode, 0 = normal mode |
| slow_en | output | 1 | One-cycle request for a slow-spaced test-clock edge |
| rated_en | output | 1 | One-cycle request for the rated-spaced capture edge |
| pi_v2 | output | 1 | Primary inputs select: 1 = apply V2 |
| shift_in_valid | output | 1 | Current shift loads a V1 bit |
| shift_out_valid | output | 1 | Current shift unloads a result bit |
| busy | output | 1 | Sequence in progress |

## Verification
Every internal phase of this block shows at the ports within one slow gap. A wrong phase or a stale launch mode gives a scan_en level that disagrees with the mode at the launch strobe, or a rated_en that is not exactly RATED_GAP cycles after the launch. A wrong bit count shows as a load or unload burst that is not CHAIN_LEN strobes long. A timer fault shifts some gap between consecutive strobes. The bench records every strobe with its cycle and the control levels, plus the per-cycle scan_en level. It then compares the whole waveform with the one expected for single patterns in both modes and for an overlapped pair with a mid-load mode change.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_LAUNCH,
        PH_CAPTURE
    } phase_e;

    typedef enum logic {
        LAUNCH_BY_SHIFT = 1'b0,
        LAUNCH_BY_FUNC  = 1'b1
    } launch_e;

    typedef struct packed {
        logic    loading;
        logic    unloading;
        launch_e mode;
    } shift_ctx_t;

    // bits needed to hold values 0 .. n-1 (at least one)
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer
    import scan_seq_pkg::*;
#(
    parameter int MAX_GAP = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [bits_for(MAX_GAP)-1:0] load_val,
    output logic                        expired
);
    localparam int TW = bits_for(MAX_GAP);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R2: a reload is taken exactly as requested
    p_timer_reload_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/seq_bit_counter.sv
module seq_bit_counter
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = bits_for(CHAIN_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(CHAIN_LEN - 1));

    // R2/R7: a shift burst never runs past the chain length
    p_bit_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(CHAIN_LEN - 1));

endmodule

// File: rtl/scan_launch_seq.sv
module scan_launch_seq
    import scan_seq_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int SLOW_GAP  = 6,
    parameter int RATED_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pattern_req,
    input  logic launch_sel,
    output logic scan_en,
    output logic slow_en,
    output logic rated_en,
    output logic pi_v2,
    output logic shift_in_valid,
    output logic shift_out_valid,
    output logic busy
);
    localparam int MAX_GAP = (SLOW_GAP > RATED_GAP) ? SLOW_GAP : RATED_GAP;
    localparam int TW      = bits_for(MAX_GAP);
    localparam int SW      = $clog2(RATED_GAP + 2);

    phase_e     ph, ph_nx;
    shift_ctx_t ctx, ctx_nx;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          bit_clr, bit_inc, bit_last;

    seq_gap_timer #(.MAX_GAP(MAX_GAP)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    seq_bit_counter #(.CHAIN_LEN(CHAIN_LEN)) u_bits (
        .clk  (clk),
        .rst  (rst),
        .clr  (bit_clr),
        .inc  (bit_inc),
        .last (bit_last)
    );

    always_comb begin
        ph_nx    = ph;
        ctx_nx   = ctx;
        tmr_load = 1'b0;
        tmr_val  = TW'(SLOW_GAP - 1);
        bit_clr  = 1'b0;
        bit_inc  = 1'b0;
        case (ph)
            PH_IDLE: begin
                if (pattern_req) begin
                    ph_nx    = PH_SHIFT;
                    ctx_nx   = '{loading: 1'b1, unloading: 1'b0,
                                 mode: launch_e'(launch_sel)};
                    tmr_load = 1'b1;
                    bit_clr  = 1'b1;
                end
            end
            PH_SHIFT: begin
                if (tmr_zero) begin
                    bit_inc  = 1'b1;
                    tmr_load = 1'b1;
                    if (bit_last) begin
                        bit_clr          = 1'b1;
                        ph_nx            = ctx.loading ? PH_LAUNCH : PH_IDLE;
                        ctx_nx.loading   = 1'b0;
                        ctx_nx.unloading = 1'b0;
                    end
                end
            end
            PH_LAUNCH: begin
                if (tmr_zero) begin
                    ph_nx    = PH_CAPTURE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RATED_GAP - 1);
                end
            end
            default: begin
                if (tmr_zero) begin
                    ph_nx    = PH_SHIFT;
                    ctx_nx   = '{loading: pattern_req, unloading: 1'b1,
                                 mode: pattern_req ? launch_e'(launch_sel) : ctx.mode};
                    tmr_load = 1'b1;
                    bit_clr  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            ctx <= '{loading: 1'b0, unloading: 1'b0, mode: LAUNCH_BY_SHIFT};
        end else begin
            ph  <= ph_nx;
            ctx <= ctx_nx;
        end
    end

    assign busy            = (ph != PH_IDLE);
    assign slow_en         = tmr_zero && (ph == PH_SHIFT || ph == PH_LAUNCH);
    assign rated_en        = tmr_zero && (ph == PH_CAPTURE);
    assign scan_en         = (ph == PH_SHIFT) ||
                             (ph == PH_LAUNCH && ctx.mode == LAUNCH_BY_SHIFT);
    assign pi_v2           = (ph == PH_CAPTURE);
    assign shift_in_valid  = (ph == PH_SHIFT) && ctx.loading;
    assign shift_out_valid = (ph == PH_SHIFT) && ctx.unloading;

    // ---- checker state: cycles since the last launch strobe (saturating)
    logic [SW-1:0] since_launch;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_launch <= SW'(RATED_GAP + 1);
        end else if (slow_en && ph == PH_LAUNCH) begin
            since_launch <= SW'(1);
        end else if (since_launch != SW'(RATED_GAP + 1)) begin
            since_launch <= since_launch + 1'b1;
        end
    end

    // R9: slow and rated requests are never merged
    p_no_dual_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !(slow_en && rated_en));

    // R5: capture comes exactly one rated gap after launch
    p_rated_window_r5: assert property (@(posedge clk) disable iff (rst)
        rated_en |-> (since_launch == SW'(RATED_GAP)));

    // R5/R6: capture happens in normal mode with V2 applied
    p_capture_levels_r5: assert property (@(posedge clk) disable iff (rst)
        rated_en |-> (!scan_en && pi_v2));

    // R3: shift launch keeps scan mode at the launch edge, leaves it after
    p_shift_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (slow_en && ph == PH_LAUNCH && ctx.mode == LAUNCH_BY_SHIFT)
            |-> scan_en ##1 !scan_en);

    // R4: functional launch is a normal-mode clock
    p_func_launch_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LAUNCH && ctx.mode == LAUNCH_BY_FUNC) |-> !scan_en);

    // R7: capture is followed by a scan-mode unload
    p_unload_follows_r7: assert property (@(posedge clk) disable iff (rst)
        rated_en |=> (scan_en && shift_out_valid));

    // R10: the launch mode is frozen while a load runs
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SHIFT && $past(ph) == PH_SHIFT) |-> $stable(ctx.mode));

endmodule

// File: tb/scan_launch_seq_test.sv
`timescale 1ns/1ps
module scan_launch_seq_test;
    localparam int LEN  = 8;
    localparam int SGAP = 6;
    localparam int RGAP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pattern_req = 1'b0;
    logic launch_sel = 1'b0;
    logic scan_en, slow_en, rated_en, pi_v2, shift_in_valid, shift_out_valid, busy;

    scan_launch_seq #(.CHAIN_LEN(LEN), .SLOW_GAP(SGAP), .RATED_GAP(RGAP)) uut (
        .clk(clk), .rst(rst), .pattern_req(pattern_req), .launch_sel(launch_sel),
        .scan_en(scan_en), .slow_en(slow_en), .rated_en(rated_en), .pi_v2(pi_v2),
        .shift_in_valid(shift_in_valid), .shift_out_valid(shift_out_valid), .busy(busy)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_ev = 0;
    int n_rated = 0;
    int ev_cyc [0:63];
    logic ev_rated [0:63];
    logic ev_scan [0:63];
    logic ev_in [0:63];
    logic ev_out [0:63];
    logic ev_v2 [0:63];
    logic hist [0:4095];

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc < 4096) hist[cyc] = scan_en;
        if (!rst && (slow_en || rated_en) && n_ev < 64) begin
            ev_cyc[n_ev]   = cyc;
            ev_rated[n_ev] = rated_en;
            ev_scan[n_ev]  = scan_en;
            ev_in[n_ev]    = shift_in_valid;
            ev_out[n_ev]   = shift_out_valid;
            ev_v2[n_ev]    = pi_v2;
            n_ev = n_ev + 1;
            if (rated_en) n_rated = n_rated + 1;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R7 busy returns to 0", busy, 0);
    endtask

    // check a run of slow shift strobes starting at event b
    task automatic chk_burst(input int b, input logic want_in, input logic want_out,
                             input bit gap_first, input string tag);
        for (int i = b; i < b + LEN; i++) begin
            chk(!ev_rated[i] && ev_scan[i], {tag, " slow strobe in scan mode"},
                {ev_rated[i], ev_scan[i]}, 1);
            chk(ev_in[i] == want_in && ev_out[i] == want_out, {tag, " load/unload flags"},
                {ev_in[i], ev_out[i]}, {want_in, want_out});
            chk(!ev_v2[i], "R6 pi_v2 low while shifting", ev_v2[i], 0);
            if (i > b || gap_first)
                chk(ev_cyc[i] - ev_cyc[i-1] == SGAP, {tag, " shift spacing"},
                    ev_cyc[i] - ev_cyc[i-1], SGAP);
        end
    endtask

    // check launch at event l (mode m) and capture at l+1
    task automatic chk_launch_capture(input int l, input logic m);
        int ones = 0;
        chk(!ev_rated[l], "R3/R4 launch is a slow strobe", ev_rated[l], 0);
        chk(ev_cyc[l] - ev_cyc[l-1] == SGAP, "R3/R4 launch spacing",
            ev_cyc[l] - ev_cyc[l-1], SGAP);
        chk(!ev_v2[l], "R6 pi_v2 low at launch", ev_v2[l], 0);
        if (!m) begin
            chk(ev_scan[l], "R3 scan mode at shift launch", ev_scan[l], 1);
            chk(!hist[ev_cyc[l] + 1], "R3 normal mode after launch", hist[ev_cyc[l] + 1], 0);
            chk(ev_scan[l] == 1'b1, "R10 launch mode kept", ev_scan[l], 1);
        end else begin
            for (int c = ev_cyc[l-1] + 1; c <= ev_cyc[l]; c++) if (hist[c]) ones++;
            chk(ones == 0, "R4 normal mode through functional launch", ones, 0);
        end
        chk(ev_rated[l+1], "R5 capture is rated", ev_rated[l+1], 1);
        chk(ev_cyc[l+1] - ev_cyc[l] == RGAP, "R5 launch-to-capture interval",
            ev_cyc[l+1] - ev_cyc[l], RGAP);
        chk(!ev_scan[l+1] && ev_v2[l+1], "R5 R6 capture levels",
            {ev_scan[l+1], ev_v2[l+1]}, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({scan_en, slow_en, rated_en, pi_v2, shift_in_valid, shift_out_valid, busy} == '0,
            "R1 outputs in reset",
            {scan_en, slow_en, rated_en, pi_v2, shift_in_valid, shift_out_valid, busy}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk({scan_en, slow_en, rated_en, pi_v2, shift_in_valid, shift_out_valid, busy} == '0,
            "R1 outputs after reset",
            {scan_en, slow_en, rated_en, pi_v2, shift_in_valid, shift_out_valid, busy}, 0);
    endtask

    task automatic t_single(input logic m);
        n_ev = 0;
        n_rated = 0;
        launch_sel = m;
        pattern_req = 1'b1;
        @(negedge clk);
        pattern_req = 1'b0;
        chk(busy, "R2 sequence starts", busy, 1);
        wait_idle();
        chk(n_ev == 2 * LEN + 2, "R2 R7 strobe count", n_ev, 2 * LEN + 2);
        chk(n_rated == 1, "R9 one rated strobe per pattern", n_rated, 1);
        if (n_ev == 2 * LEN + 2) begin
            chk_burst(0, 1'b1, 1'b0, 1'b0, "R2");
            chk_launch_capture(LEN, m);
            chk_burst(LEN + 2, 1'b0, 1'b1, 1'b1, "R7");
        end
        repeat (SGAP * 2) @(negedge clk);
        chk(!busy && !slow_en && !rated_en, "R7 stays idle without request",
            {busy, slow_en, rated_en}, 0);
    endtask

    task automatic t_overlap();
        int t = 0;
        n_ev = 0;
        n_rated = 0;
        launch_sel = 1'b0;
        pattern_req = 1'b1;
        @(negedge clk);
        while (n_ev < 1 && t < 500) begin @(negedge clk); t++; end
        launch_sel = 1'b1;          // mid-load change: must not affect this pattern
        while (n_rated < 1 && t < 1000) begin @(negedge clk); t++; end
        @(posedge clk);             // edge ending the capture cycle samples request
        #1 pattern_req = 1'b0;
        wait_idle();
        chk(n_ev == 3 * LEN + 4, "R8 strobe count with overlap", n_ev, 3 * LEN + 4);
        chk(n_rated == 2, "R9 rated strobes for two patterns", n_rated, 2);
        if (n_ev == 3 * LEN + 4) begin
            chk_burst(0, 1'b1, 1'b0, 1'b0, "R2");
            chk_launch_capture(LEN, 1'b0);     // R10: original shift-launch mode kept
            chk_burst(LEN + 2, 1'b1, 1'b1, 1'b1, "R8");
            chk_launch_capture(2 * LEN + 2, 1'b1);
            chk_burst(2 * LEN + 4, 1'b0, 1'b1, 1'b1, "R7");
        end
    endtask

    initial begin
        t_reset();
        t_single(1'b0);
        t_single(1'b1);
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule